// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog timer. It has a single-cycle register write port and a combinational read port. Software chooses a 4-bit timeout code and sets the enable bit. From then on it must restart the counter before the interval runs out, using a control write that carries a fixed 12-bit pattern. If the counter reaches its end, the block takes one of two expiry actions. It either drives a system-reset pulse of fixed length, or it raises a level interrupt. The configuration register picks which one.

Both the configuration word and the mode word are guarded by a 16-bit key in the upper half of the write data. A write without that key leaves the register as it was. Time is counted in half-second ticks. A prescaler makes each tick from a parameterised number of clock cycles. The timeout code maps onto a table that is not linear: each step is one second up to six seconds, then each step is two seconds up to sixteen seconds. Code zero gives the shortest interval, half a second.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, reads of every register return 0, `sys_rst_o` and `irq_o` are low, and the counter is stopped.
- R2: A write to offset 0x14 or 0x18 takes effect only when `bus_wdata[31:16]` equals 16'h16AA. With any other key, the register keeps its value and no output changes.
- R3: Register layout. Offset 0x10 is the restart register and always reads 0. Offset 0x14 holds the expiry action in bits 1:0. Offset 0x18 holds the enable in bit 0 and the timeout code in bits 7:4. All other read bits are 0, and so are reads of any other offset.
- R4: Timeout length in half-second ticks: code 0 gives 1, codes 1 to 6 give 2×code, codes 7 to 11 give 16, 20, 24, 28 and 32, and codes 12 to 15 give 32. With T clock cycles per tick, the expiry output rises exactly N×T cycles after the clock edge that took the accepted enabling mode write.
- R5: A write to offset 0x10 restarts the counter, so that expiry comes N×T cycles after that write's edge. This happens only when `bus_wdata[0]` is 1 and `bus_wdata[12:1]` equals 12'hA57, which together make the low 13 bits 13'h14AF. Any other value written to offset 0x10 has no effect.
- R6: An accepted mode write with bit 0 cleared stops the counter. No expiry follows, and a pending interrupt is cleared. A restart write while the counter is stopped does not make it expire.
- R7: Expiry action code 2'b01 drives `sys_rst_o` high for exactly RST_CYCLES consecutive cycles, starting on the edge at which the counter expires.
- R8: Expiry action code 2'b10 sets `irq_o` on the expiry edge. `irq_o` stays high until a valid restart write or a disabling mode write, and is low on the next cycle after either.
- R9: Expiry action codes 2'b00 and 2'b11 leave both outputs low at expiry.
- R10: After an expiry the counter stays at its end. No further expiry happens until the next restart or accepted mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data, key in bits 31:16 |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst_o | output | 1 | System reset pulse on expiry |
| irq_o | output | 1 | Level interrupt on expiry |

## Verification
The assertions assume that each write lasts exactly one cycle with `bus_wr` high, and that `rst_n` is held low long enough for the internal synchronizer to clear. The key and pattern checks in the assertions assume the write data is stable while `bus_wr` is high. The stimulus always drives address, data and strobe together at the falling edge and drops the strobe after one rising edge. It releases reset only after several cycles and waits through the synchronizer before the first access. The counter-stability assertion assumes that a restart never lands on a stopped counter's expiry edge. The bench meets this because it writes only while the outputs are quiet or while it is deliberately clearing them.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int          BUS_W      = 32;
  localparam int          HALF_W     = 6;
  localparam logic [15:0] WR_KEY     = 16'h16AA;
  localparam logic [11:0] KICK_MAGIC = 12'hA57;
  localparam logic [7:0]  OFS_CTRL   = 8'h10;
  localparam logic [7:0]  OFS_CFG    = 8'h14;
  localparam logic [7:0]  OFS_MODE   = 8'h18;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_RESET = 2'b01,
    ACT_IRQ   = 2'b10,
    ACT_RSVD  = 2'b11
  } expiry_act_e;

  // Timeout code to number of half-second ticks.
  function automatic logic [HALF_W-1:0] code_to_halves(input logic [3:0] code);
    logic [HALF_W-1:0] c6;
    c6 = HALF_W'(code);
    if (code == 4'd0)       return HALF_W'(1);
    else if (code <= 4'd6)  return c6 << 1;
    else if (code <= 4'd11) return (c6 << 2) - HALF_W'(12);
    else                    return HALF_W'(32);
  endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output expiry_act_e       act,
  output logic              en,
  output logic              kick,
  output logic              mode_wr,
  output logic              irq_clr,
  output logic [3:0]        load_code
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

  expiry_act_e act_q, act_d;
  logic        en_q, en_d;
  logic [3:0]  code_q, code_d;
  logic        key_ok, cfg_wr;

  always_comb begin
    key_ok  = (wdata[31:16] == WR_KEY);
    kick    = wr && (addr == A_CTRL) && wdata[0] && (wdata[12:1] == KICK_MAGIC);
    cfg_wr  = wr && (addr == A_CFG) && key_ok;
    mode_wr = wr && (addr == A_MODE) && key_ok;
    irq_clr = kick || (mode_wr && !wdata[0]);

    act_d  = act_q;
    en_d   = en_q;
    code_d = code_q;
    if (cfg_wr) act_d = expiry_act_e'(wdata[1:0]);
    if (mode_wr) begin
      en_d   = wdata[0];
      code_d = wdata[7:4];
    end
    load_code = mode_wr ? wdata[7:4] : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= ACT_NONE;
      en_q   <= 1'b0;
      code_q <= 4'd0;
    end else begin
      act_q  <= act_d;
      en_q   <= en_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CFG) rdata[1:0] = act_q;
    else if (addr == A_MODE) begin
      rdata[0]   = en_q;
      rdata[7:4] = code_q;
    end
  end

  assign act = act_q;
  assign en  = en_q;

  AST_KEY_GUARD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_MODE && wdata[31:16] != WR_KEY) |=> (en_q == $past(en_q) && code_q == $past(code_q))); // R2
  AST_KEY_GUARD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CFG && wdata[31:16] != WR_KEY) |=> (act_q == $past(act_q))); // R2
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int TICKS_PER_HALF_SEC = 12_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICKS_PER_HALF_SEC > 1) ? $clog2(TICKS_PER_HALF_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_HALF_SEC - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (restart || !run || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              reload,
  input  logic [HALF_W-1:0] reload_val,
  output logic              expire
);
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              step;

  always_comb begin
    step   = en && tick && (cnt_q != '0) && !reload;
    expire = step && (cnt_q == HALF_W'(1));
    cnt_d  = cnt_q;
    if (reload)    cnt_d = reload_val;
    else if (step) cnt_d = cnt_q - HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reload) |=> $stable(cnt_q)); // R6
  AST_SINGLE_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R10
endmodule

// File: rtl/kwdt_action.sv
module kwdt_action
  import kwdt_pkg::*;
#(
  parameter int RST_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        expire,
  input  expiry_act_e act,
  input  logic        irq_clr,
  output logic        sys_rst_o,
  output logic        irq_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] pcnt_q, pcnt_d;
  logic          irq_q, irq_d;

  always_comb begin
    pcnt_d = pcnt_q;
    if (expire && act == ACT_RESET) pcnt_d = RW'(RST_CYCLES);
    else if (pcnt_q != '0)          pcnt_d = pcnt_q - RW'(1);

    irq_d = irq_q;
    if (expire && act == ACT_IRQ) irq_d = 1'b1;
    else if (irq_clr)             irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      irq_q  <= irq_d;
    end
  end

  assign sys_rst_o = (pcnt_q != '0);
  assign irq_o     = irq_q;

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> ($past(expire) && $past(act) == ACT_RESET)); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(expire) && $past(act) == ACT_IRQ)); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_clr && !expire) |=> !irq_o); // R8
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwdt_pkg::*;
#(
  parameter int ADDR_W             = 8,
  parameter int TICKS_PER_HALF_SEC = 12_000_000,
  parameter int RST_CYCLES         = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_o,
  output logic              irq_o
);
  logic [1:0]        rsync_q;
  logic              rst_ns;
  expiry_act_e       act;
  logic              en, kick, mode_wr, irq_clr, reload, tick, expire;
  logic [3:0]        load_code;
  logic [HALF_W-1:0] reload_val;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  kwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .act(act), .en(en), .kick(kick), .mode_wr(mode_wr),
    .irq_clr(irq_clr), .load_code(load_code)
  );

  assign reload     = kick || mode_wr;
  assign reload_val = code_to_halves(load_code);

  kwdt_prescale #(.TICKS_PER_HALF_SEC(TICKS_PER_HALF_SEC)) u_pre (
    .clk(clk), .rst_n(rst_ns), .run(en), .restart(reload), .tick(tick)
  );

  kwdt_counter u_cnt (
    .clk(clk), .rst_n(rst_ns), .en(en), .tick(tick), .reload(reload),
    .reload_val(reload_val), .expire(expire)
  );

  kwdt_action #(.RST_CYCLES(RST_CYCLES)) u_act (
    .clk(clk), .rst_n(rst_ns), .expire(expire), .act(act), .irq_clr(irq_clr),
    .sys_rst_o(sys_rst_o), .irq_o(irq_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(!rst_ns) |-> (!sys_rst_o && !irq_o)); // R1
endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam int CLK_P = 10;
  localparam int T     = 3;
  localparam int RSTC  = 5;
  localparam logic [31:0] KEY = 32'h16AA_0000;
  localparam logic [31:0] KICK = 32'h0000_14AF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        sys_rst_o, irq_o;

  int cyc = 0, ref_cyc = 0, nchk = 0, nfail = 0;
  bit done = 0;

  keyed_wdog #(.ADDR_W(8), .TICKS_PER_HALF_SEC(T), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_o(sys_rst_o), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int halves(input int code);
    int secs;
    if (code == 0) return 1;
    if (code <= 6) secs = code;
    else if (code <= 11) secs = 8 + 2 * (code - 7);
    else secs = 16;
    return 2 * secs;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_cyc = cyc;
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  // latency to first expiry output, then width of reset pulse
  task automatic measure(output int lat, output int width);
    lat = -1; width = 0;
    for (int i = 0; i < 400; i++) begin
      if (sys_rst_o || irq_o) begin lat = cyc - ref_cyc; break; end
      @(negedge clk);
    end
    for (int i = 0; i < 100 && sys_rst_o; i++) begin
      width++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_o || irq_o) hits++;
    end
  endtask

  initial begin
    int lat, wid, hits, e;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h10, "R1 ctrl", 0); rd(8'h14, "R1 cfg", 0); rd(8'h18, "R1 mode", 0);
    check("R1 outputs", {sys_rst_o, irq_o}, 0);

    // R3 layout
    wr(8'h14, KEY | 32'hFFFF);          rd(8'h14, "R3 cfg bits", 3);
    wr(8'h18, KEY | 32'hFFFE);          rd(8'h18, "R3 mode bits", 32'hF0);
    rd(8'h10, "R3 ctrl reads 0", 0);    rd(8'h1C, "R3 other offset", 0);
    wr(8'h18, KEY | 32'h0);             rd(8'h18, "R3 mode clear", 0);

    // R2 key guard, every single-bit key error and no key
    wr(8'h14, KEY | 32'h1);
    for (int b = 0; b <= 16; b++) begin
      logic [31:0] bad;
      bad = (b == 16) ? 32'h0 : (KEY ^ (32'h1 << (16 + b)));
      wr(8'h14, bad | 32'h2);
      rd(8'h14, "R2 cfg kept", 1);
      wr(8'h18, bad | 32'h01);
      rd(8'h18, "R2 mode kept", 0);
    end
    quiet(20, hits); check("R2 no action", hits, 0);

    // R4 R7 R10 sweep of all timeout codes, reset action
    wr(8'h14, KEY | 32'h1);
    for (int c = 0; c < 16; c++) begin
      wr(8'h18, KEY | (32'(c) << 4) | 32'h1);
      measure(lat, wid);
      check($sformatf("R4 code %0d latency", c), lat, halves(c) * T);
      check($sformatf("R7 code %0d pulse width", c), wid, RSTC);
      quiet(2 * halves(c) * T + 10, hits);
      check($sformatf("R10 code %0d no refire", c), hits, 0);
      wr(8'h18, KEY);
    end

    // R5 valid restart mid-count
    wr(8'h18, KEY | 32'h21);
    repeat (7) @(negedge clk);
    wr(8'h10, KICK);
    measure(lat, wid);
    check("R5 restart latency", lat, halves(2) * T);
    wr(8'h18, KEY);

    // R5 invalid restart patterns are ignored
    wr(8'h18, KEY | 32'hB1);
    e = ref_cyc;
    for (int b = 0; b < 13; b++) wr(8'h10, KICK ^ (32'h1 << b));
    wr(8'h14 + 8'h08, KICK);
    ref_cyc = e;
    measure(lat, wid);
    check("R5 bad patterns ignored", lat, halves(11) * T);
    wr(8'h18, KEY);

    // R8 interrupt action
    wr(8'h14, KEY | 32'h2);
    for (int k = 0; k < 3; k++) begin
      int c;
      c = (k == 0) ? 0 : (k == 1) ? 3 : 9;
      wr(8'h18, KEY | (32'(c) << 4) | 32'h1);
      measure(lat, wid);
      check("R8 irq latency", lat, halves(c) * T);
      check("R8 no reset pulse", wid, 0);
      repeat (20) @(negedge clk);
      check("R8 irq held", irq_o, 1);
      wr(8'h10, KICK);
      check("R8 irq cleared by restart", irq_o, 0);
      measure(lat, wid);
      check("R5 restart after irq", lat, halves(c) * T);
      wr(8'h18, KEY | (32'(c) << 4));
      check("R6 irq cleared by disable", irq_o, 0);
    end

    // R6 disable stops counting
    wr(8'h14, KEY | 32'h1);
    wr(8'h18, KEY | 32'h11);
    repeat (2) @(negedge clk);
    wr(8'h18, KEY | 32'h10);
    quiet(100, hits); check("R6 stopped", hits, 0);
    wr(8'h10, KICK);
    quiet(100, hits); check("R6 restart while stopped", hits, 0);

    // R9 no-action codes
    for (int a = 0; a < 4; a += 3) begin
      wr(8'h14, KEY | 32'(a));
      wr(8'h18, KEY | 32'h01);
      quiet(40, hits);
      check($sformatf("R9 action %0d silent", a), hits, 0);
      rd(8'h18, "R9 still enabled", 32'h01);
      wr(8'h18, KEY);
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule